// File: doc/BRIEF.md
# E1 Spare Bit Receive Extractor

This block sits behind an E1 framer that has already found frame alignment. It takes the received bit stream one bit per strobe, with a marker on the first bit of every frame and a phase input. At the marker, the phase input says whether the frame is an alignment frame or a non-alignment frame. Frame alignment search, CRC-4 checking and line decoding are done elsewhere.

The block has three outputs:
- A serial link output that repeats every received bit.
- A link clock that pulses only on the national (Sa4 to Sa8) bit positions of the non-alignment frame selected by a 5-bit mask.
- A frame sync pulse on bit 1 of every frame, which is the international (Si) bit position.

Once per double frame, it also latches the timeslot-0 byte of an alignment frame and the timeslot-0 byte of the non-alignment frame that follows it. Both bytes are latched together as a pair, and a sticky status flag is raised when this happens. The host then has one double-frame period (250 µs at the default frame length) to read the pair before it is replaced.

Bits are counted 1 to 8 in transmission order inside timeslot 0. The first bit received is the MSB of a captured byte. In the non-alignment frame, the bits are:

| Bit | Contents |
|-----|----------|
| 1 | Si |
| 2 | fixed 1 |
| 3 | remote alarm |
| 4 to 8 | Sa4 to Sa8 |

The control state machine has five states:
- `ST_HUNT`: no valid frame position.
- `ST_FAS_TS0`: collecting the alignment-frame timeslot 0.
- `ST_FAS_BODY`: rest of an alignment frame.
- `ST_NFAS_TS0`: collecting the non-alignment-frame timeslot 0.
- `ST_NFAS_BODY`: rest of a non-alignment frame.

Its transitions, all taken only on a bit strobe, are:
- **start-of-frame**: from any state, a strobe with the marker enters `ST_FAS_TS0` or `ST_NFAS_TS0` according to the phase input.
- **ts0-done**: the 8th bit moves a TS0 state to its BODY state.
- **marker-missing**: a strobe that ends the frame count with no marker moves any frame state to `ST_HUNT`.

Otherwise the state holds.

Top module: `e1_spare_rx`

## Requirements
- R1: After reset, `link_data`, `link_clk`, `frame_sync` and `pair_flag` are 0, and `fas_byte` and `nfas_byte` are 0x00.
- R2: One cycle after each cycle with `bit_vld`=1, `link_data` equals the `rx_bit` of that cycle. With `bit_vld`=0, `link_data` holds its value.
- R3: `link_clk` is high for exactly the one cycle after a strobe carrying timeslot-0 bit 4+k of a non-alignment frame whose `sa_clk_mask[k]` is 1 (k=0 is Sa4, k=4 is Sa8). It stays low in alignment frames, on all other bit positions, and on Sa bits whose mask bit is 0.
- R4: `frame_sync` is high for the one cycle after a strobe that carries `frame_start`=1, marking the Si bit position.
- R5: One cycle after the 8th timeslot-0 bit of a non-alignment frame, if the previous frame was an alignment frame, `fas_byte` and `nfas_byte` take together the timeslot-0 bytes of those two frames, first-received bit in bit 7.
- R6: `pair_flag` becomes 1 in the same cycle as the R5 update.
- R7: `pair_flag` stays 1 until `flag_clr`=1 is applied. A clear in the same cycle as a new R5 update leaves the flag at 1.
- R8: A non-alignment frame that does not directly follow an alignment frame leaves `fas_byte`, `nfas_byte` and `pair_flag` unchanged.
- R9: If a frame of `FRAME_BITS` strobes ends with no `frame_start` on the next strobe, the block enters `ST_HUNT`. In `ST_HUNT` it gives no link clock pulses and no capture until a marker arrives, and a non-alignment frame right after that marker does not update the registers.
- R10: When an alignment frame follows another alignment frame, the earlier byte is discarded. The next pair holds the later alignment byte, and the registers hold unchanged between updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Received data bit |
| bit_vld | input | 1 | Strobe: `rx_bit` is a new bit this cycle |
| frame_start | input | 1 | Qualified by `bit_vld`: this bit is bit 1 of a frame |
| nfas_phase | input | 1 | Sampled with `frame_start`: 1 = non-alignment frame, 0 = alignment frame |
| sa_clk_mask | input | SA_COUNT | Link clock enable per Sa bit, bit 0 = Sa4 |
| flag_clr | input | 1 | Writes 1 to clear `pair_flag` |
| link_data | output | 1 | All received bits, one cycle delayed |
| link_clk | output | 1 | Pulse on the enabled Sa bits |
| frame_sync | output | 1 | Pulse on bit 1 (Si) of each frame |
| fas_byte | output | TS0_BITS | Latched alignment-frame timeslot 0 |
| nfas_byte | output | TS0_BITS | Latched non-alignment-frame timeslot 0 |
| pair_flag | output | 1 | Sticky: new pair latched |

## Verification
The bench builds the block with `FRAME_BITS`=32 and keeps the default timeslot-0 width and Sa count. The shorter frame lets dozens of double frames run in a few thousand cycles. It also makes the marker-missing wrap and the recovery from `ST_HUNT` reachable. At this length the bench can try several mask patterns, a clear that coincides with a capture, back-to-back frames of one phase, and strobes with gaps between them.

// File: rtl/e1sx_pkg.sv
package e1sx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_FAS_TS0,
        ST_FAS_BODY,
        ST_NFAS_TS0,
        ST_NFAS_BODY
    } ts0_state_e;

endpackage

// File: rtl/e1sx_bit_pos.sv
module e1sx_bit_pos #(
    parameter int FRAME_BITS = 256,
    parameter int POS_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             frame_start,
    output logic [POS_W-1:0] cur_pos,
    output logic             wrap_miss
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic [POS_W-1:0] pos_q;

    // position of the bit offered in this cycle
    always_comb begin
        if (frame_start) begin
            cur_pos = '0;
        end else if (pos_q == LAST_POS) begin
            cur_pos = '0;
        end else begin
            cur_pos = pos_q + 1'b1;
        end
    end

    // a frame ran out and no marker came with the next bit
    assign wrap_miss = bit_vld && !frame_start && (pos_q == LAST_POS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= LAST_POS;
        end else if (bit_vld) begin
            pos_q <= cur_pos;
        end
    end
endmodule

// File: rtl/e1sx_ts0_fsm.sv
module e1sx_ts0_fsm
    import e1sx_pkg::*;
#(
    parameter int TS0_BITS = 8,
    parameter int POS_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             frame_start,
    input  logic             nfas_phase,
    input  logic [POS_W-1:0] cur_pos,
    input  logic             wrap_miss,
    output logic             cur_live,
    output logic             cur_nfas,
    output logic             ts0_shift,
    output logic             fas_done,
    output logic             nfas_done
);
    localparam logic [POS_W-1:0] TS0_LAST = POS_W'(TS0_BITS - 1);

    ts0_state_e state_q;
    ts0_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        if (bit_vld) begin
            if (frame_start) begin
                state_d = nfas_phase ? ST_NFAS_TS0 : ST_FAS_TS0;
            end else begin
                unique case (state_q)
                    ST_HUNT: state_d = ST_HUNT;
                    ST_FAS_TS0: begin
                        if (wrap_miss) begin
                            state_d = ST_HUNT;
                        end else if (cur_pos == TS0_LAST) begin
                            state_d = ST_FAS_BODY;
                        end
                    end
                    ST_NFAS_TS0: begin
                        if (wrap_miss) begin
                            state_d = ST_HUNT;
                        end else if (cur_pos == TS0_LAST) begin
                            state_d = ST_NFAS_BODY;
                        end
                    end
                    ST_FAS_BODY, ST_NFAS_BODY: begin
                        if (wrap_miss) begin
                            state_d = ST_HUNT;
                        end
                    end
                    default: state_d = ST_HUNT;
                endcase
            end
        end

        cur_live  = (state_d != ST_HUNT);
        cur_nfas  = (state_d == ST_NFAS_TS0) || (state_d == ST_NFAS_BODY);
        ts0_shift = bit_vld && cur_live && (cur_pos <= TS0_LAST);
        fas_done  = ts0_shift && !cur_nfas && (cur_pos == TS0_LAST);
        nfas_done = ts0_shift && cur_nfas && (cur_pos == TS0_LAST);
    end
endmodule

// File: rtl/e1sx_pair_regs.sv
module e1sx_pair_regs #(
    parameter int TS0_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_bit,
    input  logic                bit_vld,
    input  logic                cur_live,
    input  logic                ts0_shift,
    input  logic                fas_done,
    input  logic                nfas_done,
    input  logic                flag_clr,
    output logic [TS0_BITS-1:0] fas_byte,
    output logic [TS0_BITS-1:0] nfas_byte,
    output logic                pair_flag
);
    logic [TS0_BITS-1:0] shreg_q;
    logic [TS0_BITS-1:0] shreg_nx;
    logic [TS0_BITS-1:0] pend_q;
    logic                pend_ok_q;
    logic                commit;

    assign shreg_nx = {shreg_q[TS0_BITS-2:0], rx_bit};
    assign commit   = nfas_done && pend_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            pend_q    <= '0;
            pend_ok_q <= 1'b0;
            fas_byte  <= '0;
            nfas_byte <= '0;
            pair_flag <= 1'b0;
        end else begin
            if (ts0_shift) begin
                shreg_q <= shreg_nx;
            end
            if (bit_vld && !cur_live) begin
                pend_ok_q <= 1'b0;
            end else if (fas_done) begin
                pend_q    <= shreg_nx;
                pend_ok_q <= 1'b1;
            end else if (nfas_done) begin
                pend_ok_q <= 1'b0;
            end
            if (commit) begin
                fas_byte  <= pend_q;
                nfas_byte <= shreg_nx;
            end
            if (commit) begin
                pair_flag <= 1'b1;
            end else if (flag_clr) begin
                pair_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/e1sx_link_out.sv
module e1sx_link_out #(
    parameter int POS_W    = 8,
    parameter int SA_FIRST = 3,
    parameter int SA_COUNT = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_bit,
    input  logic                bit_vld,
    input  logic                frame_start,
    input  logic                cur_live,
    input  logic                cur_nfas,
    input  logic [POS_W-1:0]    cur_pos,
    input  logic [SA_COUNT-1:0] sa_clk_mask,
    output logic                link_data,
    output logic                link_clk,
    output logic                frame_sync
);
    logic [SA_COUNT-1:0] sa_hit;

    for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
        assign sa_hit[k] = sa_clk_mask[k] && (cur_pos == POS_W'(SA_FIRST + k));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_data  <= 1'b0;
            link_clk   <= 1'b0;
            frame_sync <= 1'b0;
        end else begin
            if (bit_vld) begin
                link_data <= rx_bit;
            end
            link_clk   <= bit_vld && cur_live && cur_nfas && (|sa_hit);
            frame_sync <= bit_vld && frame_start;
        end
    end
endmodule

// File: rtl/e1_spare_rx.sv
module e1_spare_rx #(
    parameter int FRAME_BITS = 256,
    parameter int TS0_BITS   = 8,
    parameter int SA_FIRST   = 3,
    parameter int SA_COUNT   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_bit,
    input  logic                bit_vld,
    input  logic                frame_start,
    input  logic                nfas_phase,
    input  logic [SA_COUNT-1:0] sa_clk_mask,
    input  logic                flag_clr,
    output logic                link_data,
    output logic                link_clk,
    output logic                frame_sync,
    output logic [TS0_BITS-1:0] fas_byte,
    output logic [TS0_BITS-1:0] nfas_byte,
    output logic                pair_flag
);
    localparam int POS_W = $clog2(FRAME_BITS);

    logic [POS_W-1:0] cur_pos;
    logic             wrap_miss;
    logic             cur_live;
    logic             cur_nfas;
    logic             ts0_shift;
    logic             fas_done;
    logic             nfas_done;

    e1sx_bit_pos #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .frame_start(frame_start),
        .cur_pos(cur_pos), .wrap_miss(wrap_miss)
    );

    e1sx_ts0_fsm #(.TS0_BITS(TS0_BITS), .POS_W(POS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .frame_start(frame_start),
        .nfas_phase(nfas_phase), .cur_pos(cur_pos), .wrap_miss(wrap_miss),
        .cur_live(cur_live), .cur_nfas(cur_nfas), .ts0_shift(ts0_shift),
        .fas_done(fas_done), .nfas_done(nfas_done)
    );

    e1sx_pair_regs #(.TS0_BITS(TS0_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_vld(bit_vld),
        .cur_live(cur_live), .ts0_shift(ts0_shift), .fas_done(fas_done),
        .nfas_done(nfas_done), .flag_clr(flag_clr), .fas_byte(fas_byte),
        .nfas_byte(nfas_byte), .pair_flag(pair_flag)
    );

    e1sx_link_out #(.POS_W(POS_W), .SA_FIRST(SA_FIRST), .SA_COUNT(SA_COUNT)) u_link (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_vld(bit_vld),
        .frame_start(frame_start), .cur_live(cur_live), .cur_nfas(cur_nfas),
        .cur_pos(cur_pos), .sa_clk_mask(sa_clk_mask), .link_data(link_data),
        .link_clk(link_clk), .frame_sync(frame_sync)
    );
endmodule

// File: rtl/e1_spare_rx_chk.sv
module e1_spare_rx_chk #(
    parameter int TS0_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_bit,
    input logic                bit_vld,
    input logic                frame_start,
    input logic                flag_clr,
    input logic                link_data,
    input logic                link_clk,
    input logic                frame_sync,
    input logic [TS0_BITS-1:0] fas_byte,
    input logic [TS0_BITS-1:0] nfas_byte,
    input logic                pair_flag
);
    assert_link_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> (link_data == $past(rx_bit)));

    assert_link_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(link_data));

    assert_link_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        link_clk |-> ($past(bit_vld) && !$past(frame_start)));

    assert_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && frame_start) |=> frame_sync);

    assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fas_byte) || !$stable(nfas_byte)) |-> (pair_flag && $past(bit_vld)));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair_flag) |-> $past(bit_vld));

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_flag && !flag_clr) |=> pair_flag);
endmodule

bind e1_spare_rx e1_spare_rx_chk #(.TS0_BITS(TS0_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_vld(bit_vld),
    .frame_start(frame_start), .flag_clr(flag_clr), .link_data(link_data),
    .link_clk(link_clk), .frame_sync(frame_sync), .fas_byte(fas_byte),
    .nfas_byte(nfas_byte), .pair_flag(pair_flag)
);

// File: tb/e1_spare_rx_test.sv
`timescale 1ns/1ps
module e1_spare_rx_test;
    localparam int F = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0, bit_vld = 1'b0, frame_start = 1'b0, nfas_phase = 1'b0, flag_clr = 1'b0;
    logic [4:0] sa_clk_mask = '0;
    logic       link_data, link_clk, frame_sync, pair_flag;
    logic [7:0] fas_byte, nfas_byte;

    always #2.5 clk = ~clk;

    e1_spare_rx #(.FRAME_BITS(F)) uut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_vld(bit_vld),
        .frame_start(frame_start), .nfas_phase(nfas_phase), .sa_clk_mask(sa_clk_mask),
        .flag_clr(flag_clr), .link_data(link_data), .link_clk(link_clk),
        .frame_sync(frame_sync), .fas_byte(fas_byte), .nfas_byte(nfas_byte),
        .pair_flag(pair_flag)
    );

    typedef struct packed {
        logic       ld, lc, sy, fl;
        logic [7:0] fb, nb;
        logic [3:0] tg;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    logic [3:0] cur_tag = 4'd5;

    // reference model state
    int m_pos = 0;
    logic m_hunt = 1'b1, m_nf = 1'b0, m_ld = 1'b0, m_fl = 1'b0, m_pok = 1'b0;
    logic [7:0] m_sh = '0, m_pend = '0, m_fb = '0, m_nb = '0;
    logic [15:0] lf = 16'hACE1;

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd5:  return "R5";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exv);
        checks++;
        if (act !== exv) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", rq, what, act, exv, $time);
        end
    endtask

    task automatic drive(input logic b, input logic vld, input logic sof, input logic nph, input logic clr);
        logic set;
        logic lc;
        @(negedge clk);
        rx_bit = b; bit_vld = vld; frame_start = sof; nfas_phase = nph; flag_clr = clr;
        set = 1'b0; lc = 1'b0;
        if (vld) begin
            m_ld = b;
            if (sof) begin
                m_pos = 0; m_hunt = 1'b0; m_nf = nph;
            end else if (!m_hunt) begin
                if (m_pos == F - 1) m_hunt = 1'b1;
                else m_pos++;
            end
            if (m_hunt) begin
                m_pok = 1'b0;
            end else if (m_pos < 8) begin
                m_sh = {m_sh[6:0], b};
                if (m_pos == 7) begin
                    if (!m_nf) begin
                        m_pend = m_sh; m_pok = 1'b1;
                    end else begin
                        if (m_pok) begin
                            m_fb = m_pend; m_nb = m_sh; set = 1'b1;
                        end
                        m_pok = 1'b0;
                    end
                end
            end
            lc = !m_hunt && m_nf && m_pos >= 3 && m_pos <= 7 && sa_clk_mask[m_pos - 3];
        end
        if (set) m_fl = 1'b1;
        else if (clr) m_fl = 1'b0;
        q.push_back('{ld: m_ld, lc: lc, sy: vld && sof, fl: m_fl, fb: m_fb, nb: m_nb, tg: cur_tag});
    endtask

    task automatic send_frame(input logic nph, input logic [7:0] ts0, input logic mark,
                              input logic gap, input int clr_idx);
        for (int i = 0; i < F; i++) begin
            logic b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b = (i < 8) ? ts0[7 - i] : lf[0];
            drive(b, 1'b1, mark && (i == 0), nph, i == clr_idx);
            if (gap && (i % 4 == 1)) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R2", {"link_data/", tname(e.tg)}, {7'd0, link_data}, {7'd0, e.ld});
            chk("R3", {"link_clk/", tname(e.tg)}, {7'd0, link_clk}, {7'd0, e.lc});
            chk("R4", "frame_sync", {7'd0, frame_sync}, {7'd0, e.sy});
            chk("R6", {"pair_flag/", tname(e.tg)}, {7'd0, pair_flag}, {7'd0, e.fl});
            chk("R5", {"fas_byte/", tname(e.tg)}, fas_byte, e.fb);
            chk("R5", {"nfas_byte/", tname(e.tg)}, nfas_byte, e.nb);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "link_data", {7'd0, link_data}, 8'd0);
        chk("R1", "link_clk", {7'd0, link_clk}, 8'd0);
        chk("R1", "frame_sync", {7'd0, frame_sync}, 8'd0);
        chk("R1", "pair_flag", {7'd0, pair_flag}, 8'd0);
        chk("R1", "fas_byte", fas_byte, 8'h00);
        chk("R1", "nfas_byte", nfas_byte, 8'h00);
        rst_n = 1'b1;

        // R5 R6 R3: first double frame, alternating Sa mask
        cur_tag = 4'd5; sa_clk_mask = 5'b10101;
        send_frame(1'b0, 8'h9B, 1'b1, 1'b0, -1);
        send_frame(1'b1, 8'hD5, 1'b1, 1'b0, -1);
        // R7: host clear
        cur_tag = 4'd7;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        // R3: all Sa bits enabled
        cur_tag = 4'd3; sa_clk_mask = 5'b11111;
        send_frame(1'b0, 8'h1B, 1'b1, 1'b0, -1);
        // R7: clear coincides with the capture bit: set wins
        cur_tag = 4'd7;
        send_frame(1'b1, 8'hE6, 1'b1, 1'b0, 7);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        // R3: no Sa enabled, then only Sa7
        cur_tag = 4'd3; sa_clk_mask = 5'b00000;
        send_frame(1'b0, 8'h2A, 1'b1, 1'b0, -1);
        send_frame(1'b1, 8'h4C, 1'b1, 1'b0, -1);
        sa_clk_mask = 5'b01000;
        send_frame(1'b0, 8'h3C, 1'b1, 1'b0, -1);
        send_frame(1'b1, 8'hF1, 1'b1, 1'b0, -1);
        // R8: non-alignment frame after a non-alignment frame
        cur_tag = 4'd8;
        send_frame(1'b1, 8'h77, 1'b1, 1'b0, -1);
        // R10: two alignment frames in a row, later one wins
        cur_tag = 4'd10;
        send_frame(1'b0, 8'h11, 1'b1, 1'b0, -1);
        send_frame(1'b0, 8'h22, 1'b1, 1'b0, -1);
        send_frame(1'b1, 8'hC3, 1'b1, 1'b0, -1);
        // R9: missing marker drops to hunt
        cur_tag = 4'd9; sa_clk_mask = 5'b11111;
        send_frame(1'b0, 8'h5A, 1'b1, 1'b0, -1);
        send_frame(1'b1, 8'hA5, 1'b0, 1'b0, -1);
        send_frame(1'b1, 8'h66, 1'b1, 1'b0, -1);
        send_frame(1'b0, 8'h0F, 1'b1, 1'b0, -1);
        send_frame(1'b1, 8'hF0, 1'b1, 1'b0, -1);
        // R2: strobes with gaps
        cur_tag = 4'd2; sa_clk_mask = 5'b10010;
        send_frame(1'b0, 8'h81, 1'b1, 1'b1, -1);
        send_frame(1'b1, 8'h7E, 1'b1, 1'b1, -1);
        repeat (3) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        wait (q.size() == 0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule